// File: doc/BRIEF.md
# Transactional Read/Write Set Conflict Tracker

This block keeps the bookkeeping for one hardware transaction. While a transaction runs, it records every cache line that the local core loads or stores, keeping a read set and a write set per line. It compares each incoming coherence snoop against those sets. The address is a physical byte address, and lines are 64 bytes wide. The block then decides whether the transaction must be abandoned or may finish. It does not hold any line data, does not implement the coherence protocol and does not replay execution. It only tracks state and issues the abort or commit verdict.

The tracker is a two-state controller. **ST_IDLE** means no transaction is open. **ST_ACTIVE** means the tracking table and the read signature are live. There are five named transitions:

- **T_START** (ST_IDLE to ST_ACTIVE) fires on `txn_start`.
- **T_CONFLICT** (ST_ACTIVE to ST_IDLE) fires on a snoop conflict.
- **T_CAPACITY** (ST_ACTIVE to ST_IDLE) fires when a written line is evicted, or when the line table has no room for a new line.
- **T_SWABORT** (ST_ACTIVE to ST_IDLE) fires on `txn_abort`.
- **T_COMMIT** (ST_ACTIVE to ST_IDLE) fires on `txn_commit`.

When more than one cause is present in the same cycle, they are ranked conflict, capacity, software abort, commit. Every transition back to ST_IDLE wipes all tracking state in one cycle.

A read-only line that the cache evicts leaves the table. It is folded into a small hashed bit signature, so later snoop writes still catch it. The signature can report a false conflict but never misses a real one. Written lines are reported to the snoop side as hidden through a combinational flag until the transaction commits.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset, `txn_active`, `abort_pulse` and `commit_done` are 0 and `abort_reason` is 0 (none).
- R2: Addresses are compared by line only: bits [5:0] are ignored, so 0x1040 and 0x107F name the same line.
- R3: While active, a snoop write to a line in the read set raises `abort_pulse` for exactly one cycle after the edge that samples it. At that edge `abort_reason` becomes 1 (conflict) and the block returns to idle.
- R4: A snoop read to a line in the write set aborts with reason 1. A snoop read to a line that is only in the read set has no effect.
- R5: `snp_hide` is high in the same cycle when an active transaction sees a valid snoop whose line is already in the write set. It is low for read-only lines.
- R6: Evicting a line of the write set aborts with reason 2 (capacity). So does a local access to a new line when all NLINES table entries (8 by default) are in use.
- R7: Evicting a line that is only in the read set causes no abort. A later snoop write to that line still aborts with reason 1, and a later snoop read to it does not.
- R8: `txn_abort` while active aborts with reason 3 (explicit).
- R9: `txn_commit` while active raises `commit_done` for one cycle after the sampling edge and returns to idle. Lines tracked by that transaction no longer conflict in the next transaction.
- R10: A snoop in the same cycle as `txn_commit` is judged against the pre-commit sets. A conflicting snoop aborts with reason 1, and `commit_done` stays low.
- R11: `abort_reason` holds its value through idle cycles and is cleared to 0 by the edge that samples `txn_start`.
- R12: An abort clears the table and the read signature, so a line evicted from the read set before the abort no longer conflicts after a new start.
- R13: While idle, `txn_commit`, `txn_abort`, snoops, accesses and evictions produce no pulse and do not start a transaction.
- R14: A local access and a snoop to the same line in the same cycle conflict (reason 1) when either of them is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Open a transaction (ignored while active) |
| txn_commit | input | 1 | Request commit of the open transaction |
| txn_abort | input | 1 | Software-requested abort |
| acc_valid | input | 1 | Local transactional access present |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | AW | Physical byte address of the local access |
| snp_valid | input | 1 | Coherence snoop present |
| snp_write | input | 1 | 1 = snoop for ownership (write), 0 = read |
| snp_addr | input | AW | Physical byte address of the snoop |
| ev_valid | input | 1 | Cache eviction notice present |
| ev_addr | input | AW | Physical byte address of the evicted line |
| txn_active | output | 1 | Transaction open |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_reason | output | 2 | 0 none, 1 conflict, 2 capacity, 3 explicit |
| commit_done | output | 1 | One-cycle commit indication |
| snp_hide | output | 1 | Snooped line is transactionally written and must not be exposed |

## Verification
Commit and a conflicting snoop can arrive in the same cycle, and so can a local store and a snoop to the same line. The bench provokes the first by raising `txn_commit` together with a snoop write to a line read earlier. It requires an abort with reason 1 and no `commit_done` one cycle later. It provokes the second by driving a local store and a snoop read of that same, untracked line in one cycle, which must also be judged a conflict.

// File: rtl/txct_pkg.sv
`timescale 1ns/1ps
package txct_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } txct_state_e;

    typedef enum logic [1:0] {
        RSN_NONE     = 2'd0,
        RSN_CONFLICT = 2'd1,
        RSN_CAPACITY = 2'd2,
        RSN_EXPLICIT = 2'd3
    } txct_reason_e;
endpackage

// File: rtl/txct_line_table.sv
`timescale 1ns/1ps
module txct_line_table #(
    parameter int NLINES = 8,
    parameter int TAGW   = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            acc_en,
    input  logic            acc_wr,
    input  logic [TAGW-1:0] acc_tag,
    input  logic            ev_en,
    input  logic [TAGW-1:0] ev_tag,
    input  logic [TAGW-1:0] snp_tag,
    output logic            snp_rd_hit,
    output logic            snp_wr_hit,
    output logic            ev_wr_hit,
    output logic            ev_rd_only,
    output logic            acc_full
);
    logic [NLINES-1:0] vld_q, rd_q, wr_q;
    logic [TAGW-1:0]   tag_q [NLINES];

    logic [NLINES-1:0] acc_m, ev_m, snp_m;
    logic [NLINES-1:0] alloc_oh;
    logic              acc_hit, slot_found;

    // Tag comparators, one per entry
    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_cmp
            assign acc_m[g] = vld_q[g] && (tag_q[g] == acc_tag);
            assign ev_m[g]  = vld_q[g] && (tag_q[g] == ev_tag);
            assign snp_m[g] = vld_q[g] && (tag_q[g] == snp_tag);
        end
    endgenerate

    // Lowest free slot for a newly touched line
    always_comb begin
        alloc_oh   = '0;
        slot_found = 1'b0;
        for (int i = 0; i < NLINES; i++) begin
            if (!slot_found && !vld_q[i]) begin
                alloc_oh[i] = 1'b1;
                slot_found  = 1'b1;
            end
        end
    end

    assign acc_hit    = |acc_m;
    assign acc_full   = acc_en && !acc_hit && !slot_found;
    assign snp_rd_hit = |(snp_m & rd_q);
    assign snp_wr_hit = |(snp_m & wr_q);
    assign ev_wr_hit  = ev_en && |(ev_m & wr_q);
    assign ev_rd_only = ev_en && |(ev_m & rd_q & ~wr_q);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vld_q <= '0;
            rd_q  <= '0;
            wr_q  <= '0;
        end else begin
            for (int i = 0; i < NLINES; i++) begin
                if (ev_en && ev_m[i] && !wr_q[i]) begin
                    vld_q[i] <= 1'b0;
                    rd_q[i]  <= 1'b0;
                end
                if (acc_en && (acc_m[i] || (!acc_hit && alloc_oh[i]))) begin
                    vld_q[i] <= 1'b1;
                    if (acc_wr) wr_q[i] <= 1'b1;
                    else        rd_q[i] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) tag_q[i] <= '0;
        end else begin
            for (int i = 0; i < NLINES; i++) begin
                if (acc_en && !acc_hit && alloc_oh[i]) tag_q[i] <= acc_tag;
            end
        end
    end

    AST_TABLE_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!snp_rd_hit && !snp_wr_hit)); // R9
endmodule

// File: rtl/txct_read_sig.sv
`timescale 1ns/1ps
module txct_read_sig #(
    parameter int TAGW = 26,
    parameter int SIGW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            ins_en,
    input  logic [TAGW-1:0] ins_tag,
    input  logic [TAGW-1:0] qry_tag,
    output logic            qry_hit
);
    localparam int HW = (SIGW > 1) ? $clog2(SIGW) : 1;

    logic [SIGW-1:0] bits_q;

    function automatic logic [HW-1:0] fold(input logic [TAGW-1:0] t);
        logic [HW-1:0] h;
        h = '0;
        for (int i = 0; i < TAGW; i++) h[i % HW] = h[i % HW] ^ t[i];
        return h;
    endfunction

    logic [HW-1:0] ins_idx, qry_idx;
    assign ins_idx = fold(ins_tag);
    assign qry_idx = fold(qry_tag);
    assign qry_hit = bits_q[qry_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) bits_q <= '0;
        else if (ins_en)     bits_q[ins_idx] <= 1'b1;
    end
endmodule

// File: rtl/txct_fsm.sv
`timescale 1ns/1ps
module txct_fsm
    import txct_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_req,
    input  logic         commit_req,
    input  logic         abort_req,
    input  logic         conflict,
    input  logic         capacity,
    output logic         active,
    output logic         clear,
    output logic         abort_pulse,
    output txct_reason_e reason,
    output logic         commit_done
);
    txct_state_e  state_q, state_d;
    txct_reason_e cause;
    logic         kill;

    assign kill = conflict || capacity || abort_req;

    always_comb begin
        if (conflict)      cause = RSN_CONFLICT;
        else if (capacity) cause = RSN_CAPACITY;
        else               cause = RSN_EXPLICIT;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_ACTIVE;           // T_START
            ST_ACTIVE: if (kill || commit_req) state_d = ST_IDLE;    // T_CONFLICT/T_CAPACITY/T_SWABORT/T_COMMIT
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign active = (state_q == ST_ACTIVE);
    assign clear  = active && (state_d == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_pulse <= 1'b0;
            commit_done <= 1'b0;
            reason      <= RSN_NONE;
        end else begin
            abort_pulse <= 1'b0;
            commit_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) reason <= RSN_NONE;
                end
                ST_ACTIVE: begin
                    if (kill) begin
                        abort_pulse <= 1'b1;
                        reason      <= cause;
                    end else if (commit_req) begin
                        commit_done <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_pulse && commit_done)); // R10
    AST_ABORT_HAS_RSN: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (reason != RSN_NONE)); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> !active); // R9
    AST_RSN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start_req) |=> $stable(reason)); // R11
endmodule

// File: rtl/txn_conflict_tracker.sv
`timescale 1ns/1ps
module txn_conflict_tracker
    import txct_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LINE_BITS = 6,
    parameter int NLINES    = 8,
    parameter int SIGW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_start,
    input  logic          txn_commit,
    input  logic          txn_abort,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic          snp_valid,
    input  logic          snp_write,
    input  logic [AW-1:0] snp_addr,
    input  logic          ev_valid,
    input  logic [AW-1:0] ev_addr,
    output logic          txn_active,
    output logic          abort_pulse,
    output logic [1:0]    abort_reason,
    output logic          commit_done,
    output logic          snp_hide
);
    localparam int TAGW = AW - LINE_BITS;

    logic [TAGW-1:0] acc_tag, snp_tag, ev_tag;
    assign acc_tag = acc_addr[AW-1:LINE_BITS];
    assign snp_tag = snp_addr[AW-1:LINE_BITS];
    assign ev_tag  = ev_addr[AW-1:LINE_BITS];

    logic active, clear;
    logic rd_hit, wr_hit, ev_wr_hit, ev_rd_only, acc_full, sig_hit;
    logic local_coll, conflict, capacity;
    txct_reason_e reason;

    txct_line_table #(.NLINES(NLINES), .TAGW(TAGW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .acc_en     (active && acc_valid),
        .acc_wr     (acc_write),
        .acc_tag    (acc_tag),
        .ev_en      (active && ev_valid),
        .ev_tag     (ev_tag),
        .snp_tag    (snp_tag),
        .snp_rd_hit (rd_hit),
        .snp_wr_hit (wr_hit),
        .ev_wr_hit  (ev_wr_hit),
        .ev_rd_only (ev_rd_only),
        .acc_full   (acc_full)
    );

    txct_read_sig #(.TAGW(TAGW), .SIGW(SIGW)) u_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .ins_en  (ev_rd_only),
        .ins_tag (ev_tag),
        .qry_tag (snp_tag),
        .qry_hit (sig_hit)
    );

    // Same-cycle local access to the snooped line
    assign local_coll = acc_valid && (acc_tag == snp_tag) && (acc_write || snp_write);

    assign conflict = active && snp_valid &&
                      ((snp_write && (rd_hit || wr_hit || sig_hit)) ||
                       (!snp_write && wr_hit) || local_coll);
    assign capacity = active && ((ev_valid && ev_wr_hit) || acc_full);

    txct_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (txn_start),
        .commit_req  (txn_commit),
        .abort_req   (txn_abort),
        .conflict    (conflict),
        .capacity    (capacity),
        .active      (active),
        .clear       (clear),
        .abort_pulse (abort_pulse),
        .reason      (reason),
        .commit_done (commit_done)
    );

    assign txn_active   = active;
    assign abort_reason = reason;
    assign snp_hide     = active && snp_valid && wr_hit;

    AST_SNPWR_RD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && snp_valid && snp_write && rd_hit) |=> (abort_pulse && abort_reason == 2'd1)); // R3
    AST_EVWR_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ev_valid && ev_wr_hit && !conflict) |=> (abort_pulse && abort_reason == 2'd2)); // R6
    AST_SIG_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !sig_hit); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !txn_start) |=> (!abort_pulse && !commit_done && !txn_active)); // R13
endmodule

// File: tb/txn_conflict_tracker_tb_top.sv
`timescale 1ns/1ps
module txn_conflict_tracker_tb_top;
    localparam int AW = 32;
    localparam int NL = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic txn_start, txn_commit, txn_abort;
    logic acc_valid, acc_write;
    logic [AW-1:0] acc_addr;
    logic snp_valid, snp_write;
    logic [AW-1:0] snp_addr;
    logic ev_valid;
    logic [AW-1:0] ev_addr;
    logic txn_active, abort_pulse, commit_done, snp_hide;
    logic [1:0] abort_reason;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    txn_conflict_tracker #(.AW(AW), .NLINES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .txn_start(txn_start), .txn_commit(txn_commit), .txn_abort(txn_abort),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .ev_valid(ev_valid), .ev_addr(ev_addr),
        .txn_active(txn_active), .abort_pulse(abort_pulse), .abort_reason(abort_reason),
        .commit_done(commit_done), .snp_hide(snp_hide)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic quiet();
        txn_start = 0; txn_commit = 0; txn_abort = 0;
        acc_valid = 0; acc_write = 0; acc_addr = '0;
        snp_valid = 0; snp_write = 0; snp_addr = '0;
        ev_valid = 0; ev_addr = '0;
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic start_txn(input string req);
        txn_start = 1; cyc(); txn_start = 0;
        chk(req, "active after start", txn_active, 1);
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a);
        acc_valid = 1; acc_write = wr; acc_addr = a; cyc(); acc_valid = 0;
    endtask

    task automatic snoop(input logic wr, input logic [AW-1:0] a);
        snp_valid = 1; snp_write = wr; snp_addr = a; cyc(); snp_valid = 0;
    endtask

    task automatic evict(input logic [AW-1:0] a);
        ev_valid = 1; ev_addr = a; cyc(); ev_valid = 0;
    endtask

    task automatic expect_abort(input string req, input int rsn);
        chk(req, "abort_pulse", abort_pulse, 1);
        chk(req, "abort_reason", abort_reason, rsn);
        chk(req, "active after abort", txn_active, 0);
        chk(req, "no commit_done", commit_done, 0);
        cyc();
        chk(req, "abort pulse one cycle", abort_pulse, 0);
    endtask

    task automatic t_reset();
        chk("R1", "active", txn_active, 0);
        chk("R1", "abort_pulse", abort_pulse, 0);
        chk("R1", "commit_done", commit_done, 0);
        chk("R1", "abort_reason", abort_reason, 0);
    endtask

    task automatic t_line_gran();
        start_txn("R2");
        access(0, 32'h0000_1040);
        chk("R2", "no abort on load", abort_pulse, 0);
        snoop(1, 32'h0000_107F);   // same 64-byte line
        expect_abort("R3", 1);
    endtask

    task automatic t_read_write_sets();
        start_txn("R4");
        access(0, 32'h0000_2000);
        access(1, 32'h0000_3000);
        snp_valid = 1; snp_write = 0; snp_addr = 32'h0000_2008; #1;
        chk("R5", "snp_hide on read-only line", snp_hide, 0);
        cyc(); snp_valid = 0;
        chk("R4", "snoop read of read set ignored", abort_pulse, 0);
        chk("R4", "still active", txn_active, 1);
        snp_valid = 1; snp_write = 0; snp_addr = 32'h0000_3010; #1;
        chk("R5", "snp_hide on written line", snp_hide, 1);
        cyc(); snp_valid = 0;
        expect_abort("R4", 1);
    endtask

    task automatic t_evict_written();
        start_txn("R6");
        access(1, 32'h0000_4000);
        evict(32'h0000_4010);
        expect_abort("R6", 2);
    endtask

    task automatic t_overflow();
        start_txn("R6");
        for (int i = 0; i < NL; i++) begin
            access(0, 32'h0001_0000 + i * 64);
            chk("R6", "no abort while table has room", abort_pulse, 0);
        end
        access(0, 32'h0001_0000 + NL * 64);
        expect_abort("R6", 2);
    endtask

    task automatic t_evict_read();
        start_txn("R7");
        access(0, 32'h0000_5000);
        evict(32'h0000_5000);
        chk("R7", "no abort on read eviction", abort_pulse, 0);
        chk("R7", "still active", txn_active, 1);
        snoop(0, 32'h0000_5000);
        chk("R7", "snoop read of evicted line ignored", abort_pulse, 0);
        snoop(1, 32'h0000_5020);
        expect_abort("R7", 1);
    endtask

    task automatic t_sw_abort();
        start_txn("R8");
        txn_abort = 1; cyc(); txn_abort = 0;
        expect_abort("R8", 3);
    endtask

    task automatic t_commit();
        start_txn("R11");
        chk("R11", "reason cleared by start", abort_reason, 0);
        access(1, 32'h0000_6000);
        txn_commit = 1; cyc(); txn_commit = 0;
        chk("R9", "commit_done", commit_done, 1);
        chk("R9", "no abort", abort_pulse, 0);
        chk("R9", "idle after commit", txn_active, 0);
        cyc();
        chk("R9", "commit_done one cycle", commit_done, 0);
        start_txn("R9");
        snoop(1, 32'h0000_6000);
        chk("R9", "old write set cleared", abort_pulse, 0);
        txn_commit = 1; cyc(); txn_commit = 0;
        chk("R9", "second commit_done", commit_done, 1);
        cyc();
    endtask

    task automatic t_commit_race();
        start_txn("R10");
        access(0, 32'h0000_7000);
        txn_commit = 1; snp_valid = 1; snp_write = 1; snp_addr = 32'h0000_7000;
        cyc();
        txn_commit = 0; snp_valid = 0;
        expect_abort("R10", 1);
    endtask

    task automatic t_reason_hold();
        for (int i = 0; i < 3; i++) cyc();
        chk("R11", "reason held in idle", abort_reason, 1);
        txn_start = 1; cyc(); txn_start = 0;
        chk("R11", "reason cleared at start", abort_reason, 0);
        txn_abort = 1; cyc(); txn_abort = 0;
        cyc();
    endtask

    task automatic t_abort_clears();
        start_txn("R12");
        access(0, 32'h0000_8000);
        evict(32'h0000_8000);
        txn_abort = 1; cyc(); txn_abort = 0;
        chk("R12", "abort pulse", abort_pulse, 1);
        cyc();
        start_txn("R12");
        snoop(1, 32'h0000_8000);
        chk("R12", "signature cleared by abort", abort_pulse, 0);
        chk("R12", "still active", txn_active, 1);
        txn_abort = 1; cyc(); txn_abort = 0;
        cyc();
    endtask

    task automatic t_idle_ignored();
        txn_commit = 1; cyc(); txn_commit = 0;
        chk("R13", "commit idle no pulse", commit_done, 0);
        txn_abort = 1; cyc(); txn_abort = 0;
        chk("R13", "abort idle no pulse", abort_pulse, 0);
        acc_valid = 1; acc_write = 1; acc_addr = 32'h0000_A000;
        snp_valid = 1; snp_write = 1; snp_addr = 32'h0000_A000;
        ev_valid = 1; ev_addr = 32'h0000_A000;
        cyc(); quiet();
        chk("R13", "snoop idle no pulse", abort_pulse, 0);
        chk("R13", "still idle", txn_active, 0);
    endtask

    task automatic t_same_cycle();
        start_txn("R14");
        acc_valid = 1; acc_write = 1; acc_addr = 32'h0000_9000;
        snp_valid = 1; snp_write = 0; snp_addr = 32'h0000_9004;
        cyc(); quiet();
        expect_abort("R14", 1);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        quiet();
        rst_n = 0;
        cyc(); cyc(); cyc();
        rst_n = 1;
        cyc();
        t_reset();
        t_line_gran();
        t_read_write_sets();
        t_evict_written();
        t_overflow();
        t_evict_read();
        t_sw_abort();
        t_commit();
        t_commit_race();
        t_reason_hold();
        t_abort_clears();
        t_idle_ignored();
        t_same_cycle();
        finish_run();
    end
endmodule